// File: doc/BRIEF.md
# Sequential Floating-Point Divider

This block divides one single-precision binary floating-point word by another. It works over many clock cycles and uses a small datapath. A request is taken when `start` is high while the block is idle. The block then splits both words into sign, exponent field and significand. It forms the result sign and the rebiased exponent. It develops the significand quotient one bit per cycle with a restoring algorithm. It then normalizes, rounds and packs the result. One cycle of `done` announces the quotient and its flags. They stay on the outputs until the next result replaces them.

A controller sequences the work through five states:

- **IDLE**: waits for `start`.
- **DIVIDE**: develops one quotient bit each cycle.
- **NORM**: picks the leading-one position and the guard and sticky bits.
- **ROUND**: applies round-to-nearest-even and renormalizes on carry.
- **PACK**: builds the output word and raises `done`.

The transitions are:

- IDLE → DIVIDE when `start` arrives and both operands are nonzero.
- IDLE → PACK when `start` arrives and either operand is zero. This is the special-value path.
- DIVIDE → NORM after the last quotient bit.
- NORM → ROUND, ROUND → PACK and PACK → IDLE, each after one cycle.

An operand whose exponent field is zero counts as zero, whatever its fraction holds. Operands with an all-ones exponent field are not supported.

Top module: `fp_seq_divider`

## Requirements
- R1: For two nonzero operands, `done` is high for exactly one cycle, right after the 30th rising edge. The edge that accepts `start` counts as the first. With a zero operand, `done` follows the 2nd edge. `busy` is high from the accepting edge until the edge that raises `done`.
- R2: Bit 31 of the result is the exclusive OR of bit 31 of the two operands. This holds for finite, infinite and zero results.
- R3: For nonzero operands, the biased exponent is the dividend field minus the divisor field, plus 127. It is lowered by one when the dividend significand is below the divisor significand.
- R4: The 23-bit result fraction is correctly rounded to nearest, with ties to even. The block computes 26 quotient bits and a sticky bit taken from the final remainder. A carry out of the rounding sets the fraction to zero and raises the exponent by one.
- R5: If the final biased exponent is 255 or more, the result is a signed infinity (exponent field 0xFF, fraction 0) and `flag_ovf` is set. At most one of the three flags is ever set.
- R6: If the final biased exponent is 0 or less, the result is a signed zero and `flag_unf` is set.
- R7: A zero dividend with a nonzero divisor gives a signed zero with no flag. An exponent field of 0 marks a zero operand, whatever its fraction.
- R8: A nonzero dividend with a zero divisor gives a signed infinity and sets `flag_dz`.
- R9: Zero divided by zero gives the quiet NaN word 0x7FC00000, with no flag set.
- R10: The quotient and the flags change only at the edge that raises `done`. They hold until the next result.
- R11: A `start` that arrives while `busy` is high is ignored. The result and the latency of the operation in flight are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; taken only while idle |
| op_a | input | 32 | Dividend word |
| op_b | input | 32 | Divisor word |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | 32 | Packed result word |
| flag_ovf | output | 1 | Result exponent overflowed |
| flag_unf | output | 1 | Result exponent underflowed |
| flag_dz | output | 1 | Nonzero value divided by zero |

## Verification
The hardest conditions to reach are the exponent boundaries, where a single normalization decrement decides the result. One such case is a rebiased exponent of exactly 255 or exactly 1: whether the result overflows, underflows or stays normal then depends only on whether the dividend significand is below the divisor significand. The stimulus reaches these cases with operand pairs built for the purpose. Each boundary is hit from both sides: the same exponent fields are used once with a dividend significand at or above the divisor significand and once below it. A second start is also issued in the middle of a division, with different operands, to show that it leaves the operation in flight alone.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIVIDE,
        ST_NORM,
        ST_ROUND,
        ST_PACK
    } fpdiv_state_e;

endpackage

// File: rtl/fpdiv_unpack.sv
module fpdiv_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output logic                  sign,
    output logic [EXP_W-1:0]      exp_field,
    output logic [FRAC_W:0]       mant,
    output logic                  is_zero
);
    always_comb begin
        sign      = word[EXP_W+FRAC_W];
        exp_field = word[EXP_W+FRAC_W-1:FRAC_W];
        mant      = {1'b1, word[FRAC_W-1:0]};
        is_zero   = (exp_field == '0);
    end
endmodule

// File: rtl/fpdiv_iter.sv
module fpdiv_iter #(
    parameter int MANT_W = 24,
    parameter int Q_W    = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [MANT_W-1:0] dividend,
    input  logic [MANT_W-1:0] divisor,
    output logic [Q_W-1:0]    quo,
    output logic              rem_nz
);
    localparam int R_W = MANT_W + 1;

    logic [R_W-1:0]    rem_q;
    logic [MANT_W-1:0] div_q;
    logic [Q_W-1:0]    quo_q;
    logic [R_W:0]      diff;
    logic              fits;
    logic [R_W-1:0]    rem_next;

    always_comb begin
        diff     = {1'b0, rem_q} - {2'b00, div_q};
        fits     = ~diff[R_W];
        rem_next = fits ? diff[R_W-1:0] : rem_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            div_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            rem_q <= {1'b0, dividend};
            div_q <= divisor;
            quo_q <= '0;
        end else if (step) begin
            rem_q <= {rem_next[R_W-2:0], 1'b0};
            quo_q <= {quo_q[Q_W-2:0], fits};
        end
    end

    assign quo    = quo_q;
    assign rem_nz = (rem_q != '0);

    // R4: partial remainder stays below twice the divisor
    assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_q < {div_q, 1'b0}) && !rem_next[R_W-1]);
endmodule

// File: rtl/fpdiv_norm.sv
module fpdiv_norm #(
    parameter int MANT_W = 24,
    parameter int Q_W    = 26,
    parameter int EXP_SW = 10
) (
    input  logic [Q_W-1:0]           quo,
    input  logic                     rem_nz,
    input  logic signed [EXP_SW-1:0] exp_in,
    output logic [MANT_W-1:0]        mant,
    output logic                     guard,
    output logic                     sticky,
    output logic signed [EXP_SW-1:0] exp_out
);
    always_comb begin
        if (quo[Q_W-1]) begin
            mant    = quo[Q_W-1:2];
            guard   = quo[1];
            sticky  = quo[0] | rem_nz;
            exp_out = exp_in;
        end else begin
            mant    = quo[Q_W-2:1];
            guard   = quo[0];
            sticky  = rem_nz;
            exp_out = exp_in - EXP_SW'(1);
        end
    end
endmodule

// File: rtl/fpdiv_round.sv
module fpdiv_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int EXP_SW = 10
) (
    input  logic [FRAC_W:0]          mant,
    input  logic                     guard,
    input  logic                     sticky,
    input  logic signed [EXP_SW-1:0] exp_in,
    output logic [FRAC_W-1:0]        frac,
    output logic [EXP_W-1:0]         exp_field,
    output logic                     ovf,
    output logic                     unf
);
    localparam logic signed [EXP_SW-1:0] EXP_TOP  = EXP_SW'((1 << EXP_W) - 1);
    localparam logic signed [EXP_SW-1:0] EXP_NONE = EXP_SW'(0);

    logic                     bump;
    logic [FRAC_W+1:0]        sum;
    logic signed [EXP_SW-1:0] exp_fin;

    always_comb begin
        bump = guard & (sticky | mant[0]);
        sum  = {1'b0, mant} + {{(FRAC_W+1){1'b0}}, bump};
        if (sum[FRAC_W+1]) begin
            frac    = '0;
            exp_fin = exp_in + EXP_SW'(1);
        end else begin
            frac    = sum[FRAC_W-1:0];
            exp_fin = exp_in;
        end
        ovf       = (exp_fin >= EXP_TOP);
        unf       = (exp_fin <= EXP_NONE);
        exp_field = exp_fin[EXP_W-1:0];
    end
endmodule

// File: rtl/fp_seq_divider.sv
module fp_seq_divider
    import fpdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    output logic                  busy,
    output logic                  done,
    output logic [EXP_W+FRAC_W:0] quotient,
    output logic                  flag_ovf,
    output logic                  flag_unf,
    output logic                  flag_dz
);
    localparam int WORD_W = EXP_W + FRAC_W + 1;
    localparam int MANT_W = FRAC_W + 1;
    localparam int Q_W    = MANT_W + 2;
    localparam int EXP_SW = EXP_W + 2;
    localparam int CNT_W  = $clog2(Q_W);
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(Q_W - 1);

    fpdiv_state_e state_q, state_d;

    logic              a_sign, b_sign, a_zero, b_zero, any_zero;
    logic [EXP_W-1:0]  a_exp, b_exp;
    logic [MANT_W-1:0] a_mant, b_mant;

    fpdiv_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_a (
        .word(op_a), .sign(a_sign), .exp_field(a_exp), .mant(a_mant), .is_zero(a_zero)
    );
    fpdiv_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_b (
        .word(op_b), .sign(b_sign), .exp_field(b_exp), .mant(b_mant), .is_zero(b_zero)
    );

    assign any_zero = a_zero | b_zero;

    logic                     accept, load, step;
    logic [Q_W-1:0]           quo;
    logic                     rem_nz;
    logic                     sign_q;
    logic signed [EXP_SW-1:0] exp_q;
    logic [CNT_W-1:0]         cnt_q;
    logic                     special_q;
    logic [WORD_W-1:0]        spec_word_q;
    logic                     spec_dz_q;
    logic [EXP_SW-1:0]        exp_start;

    assign accept    = (state_q == ST_IDLE) && start;
    assign load      = accept && !any_zero;
    assign step      = (state_q == ST_DIVIDE);
    assign exp_start = EXP_SW'(a_exp) - EXP_SW'(b_exp) + EXP_SW'(BIAS);

    fpdiv_iter #(.MANT_W(MANT_W), .Q_W(Q_W)) u_iter (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .dividend(a_mant), .divisor(b_mant), .quo(quo), .rem_nz(rem_nz)
    );

    logic [MANT_W-1:0]        n_mant;
    logic                     n_guard, n_sticky;
    logic signed [EXP_SW-1:0] n_exp;
    logic [MANT_W-1:0]        nmant_q;
    logic                     nguard_q, nsticky_q;
    logic signed [EXP_SW-1:0] nexp_q;

    fpdiv_norm #(.MANT_W(MANT_W), .Q_W(Q_W), .EXP_SW(EXP_SW)) u_norm (
        .quo(quo), .rem_nz(rem_nz), .exp_in(exp_q),
        .mant(n_mant), .guard(n_guard), .sticky(n_sticky), .exp_out(n_exp)
    );

    logic [FRAC_W-1:0] r_frac;
    logic [EXP_W-1:0]  r_exp;
    logic              r_ovf, r_unf;
    logic [FRAC_W-1:0] frac_q;
    logic [EXP_W-1:0]  rexp_q;
    logic              rovf_q, runf_q;

    fpdiv_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EXP_SW(EXP_SW)) u_round (
        .mant(nmant_q), .guard(nguard_q), .sticky(nsticky_q), .exp_in(nexp_q),
        .frac(r_frac), .exp_field(r_exp), .ovf(r_ovf), .unf(r_unf)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = any_zero ? ST_PACK : ST_DIVIDE;
            ST_DIVIDE: if (cnt_q == LAST_BIT) state_d = ST_NORM;
            ST_NORM:   state_d = ST_ROUND;
            ST_ROUND:  state_d = ST_PACK;
            ST_PACK:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q      <= 1'b0;
            exp_q       <= '0;
            cnt_q       <= '0;
            special_q   <= 1'b0;
            spec_word_q <= '0;
            spec_dz_q   <= 1'b0;
            nmant_q     <= '0;
            nguard_q    <= 1'b0;
            nsticky_q   <= 1'b0;
            nexp_q      <= '0;
            frac_q      <= '0;
            rexp_q      <= '0;
            rovf_q      <= 1'b0;
            runf_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    sign_q    <= a_sign ^ b_sign;
                    exp_q     <= exp_start;
                    cnt_q     <= '0;
                    special_q <= any_zero;
                    spec_dz_q <= b_zero && !a_zero;
                    if (a_zero && b_zero)
                        spec_word_q <= {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
                    else if (b_zero)
                        spec_word_q <= {a_sign ^ b_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                    else
                        spec_word_q <= {a_sign ^ b_sign, {(WORD_W-1){1'b0}}};
                end
                ST_DIVIDE: cnt_q <= cnt_q + CNT_W'(1);
                ST_NORM: begin
                    nmant_q   <= n_mant;
                    nguard_q  <= n_guard;
                    nsticky_q <= n_sticky;
                    nexp_q    <= n_exp;
                end
                ST_ROUND: begin
                    frac_q <= r_frac;
                    rexp_q <= r_exp;
                    rovf_q <= r_ovf;
                    runf_q <= r_unf;
                end
                default: ;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            quotient <= '0;
            flag_ovf <= 1'b0;
            flag_unf <= 1'b0;
            flag_dz  <= 1'b0;
        end else begin
            done <= (state_q == ST_PACK);
            if (state_q == ST_PACK) begin
                flag_dz  <= special_q && spec_dz_q;
                flag_ovf <= !special_q && rovf_q;
                flag_unf <= !special_q && !rovf_q && runf_q;
                if (special_q)
                    quotient <= spec_word_q;
                else if (rovf_q)
                    quotient <= {sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                else if (runf_q)
                    quotient <= {sign_q, {(WORD_W-1){1'b0}}};
                else
                    quotient <= {sign_q, rexp_q, frac_q};
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_norm_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM) |-> (quo[Q_W-1] | quo[Q_W-2]));

    assert_flags_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0({flag_ovf, flag_unf, flag_dz}));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PACK) |=> $stable(quotient) && $stable(flag_dz));

    assert_inflight_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE) |=> $stable(sign_q) && $stable(exp_q));
endmodule

// File: tb/test_fp_seq_divider.sv
module test_fp_seq_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy, done, flag_ovf, flag_unf, flag_dz;
    logic [31:0] quotient;

    int checks = 0;
    int failures = 0;
    int unsigned lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    fp_seq_divider i_fp_seq_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .quotient(quotient),
        .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_dz(flag_dz)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference, built from the requirements
    function automatic void ref_div(input logic [31:0] a, input logic [31:0] b,
                                    output logic [31:0] q, output logic o,
                                    output logic u, output logic z, output int lat);
        logic s;
        int ea, eb, e;
        longint ma, mb, num, qq, rr, m;
        bit g, st, inc;
        s = a[31] ^ b[31];
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        o = 1'b0; u = 1'b0; z = 1'b0; lat = 2;
        if (ea == 0 && eb == 0) begin q = 32'h7FC00000; return; end
        if (eb == 0) begin q = {s, 8'hFF, 23'h0}; z = 1'b1; return; end
        if (ea == 0) begin q = {s, 31'h0}; return; end
        lat = 30;
        ma = longint'({1'b1, a[22:0]});
        mb = longint'({1'b1, b[22:0]});
        num = ma * 33554432;
        qq = num / mb;
        rr = num % mb;
        if (qq >= 33554432) begin
            m = qq / 4; g = ((qq / 2) % 2) != 0; st = ((qq % 2) != 0) || (rr != 0);
            e = ea - eb + 127;
        end else begin
            m = qq / 2; g = (qq % 2) != 0; st = (rr != 0);
            e = ea - eb + 126;
        end
        inc = g && (st || ((m % 2) != 0));
        if (inc) m = m + 1;
        if (m == 16777216) begin m = 8388608; e = e + 1; end
        if (e >= 255) begin q = {s, 8'hFF, 23'h0}; o = 1'b1; end
        else if (e <= 0) begin q = {s, 31'h0}; u = 1'b1; end
        else q = {s, e[7:0], m[22:0]};
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input string req, input bit poke_busy);
        logic [31:0] eq;
        logic eo, eu, ez;
        int lat;
        bit seen;
        ref_div(a, b, eq, eo, eu, ez, lat);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        seen = 1'b0;
        for (int k = 1; k <= 40 && !seen; k++) begin
            @(negedge clk);
            if (poke_busy && k <= 3) begin
                op_a = 32'h40000000; op_b = 32'h3F800000; start = 1'b1;   // R11
            end else begin
                start = 1'b0;
            end
            chk(done == (k == lat), "R1", "done timing", {31'h0, done}, {31'h0, k == lat});
            chk(busy == (k < lat), "R1", "busy timing", {31'h0, busy}, {31'h0, k < lat});
            if (done) begin
                seen = 1'b1;
                chk(quotient == eq, req, "quotient", quotient, eq);
                chk({flag_ovf, flag_unf, flag_dz} == {eo, eu, ez}, req, "flags",
                    {29'h0, flag_ovf, flag_unf, flag_dz}, {29'h0, eo, eu, ez});
            end
        end
        if (!seen) chk(1'b0, "R1", "done never seen", 32'h0, 32'h1);
        start = 1'b0;
        op_a = 32'h3F800000; op_b = 32'h40400000;
        repeat (3) @(negedge clk);
        // R10: result held while idle and inputs move
        chk(quotient == eq && !done, "R10", "hold after done", quotient, eq);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !busy && quotient == 32'h0 && !flag_ovf && !flag_unf && !flag_dz,
            "R1", "reset state", quotient, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(32'h40C00000, 32'hC0000000, "R2", 1'b0);   // 6 / -2
        chk(quotient == 32'hC0400000, "R2", "6/-2 literal", quotient, 32'hC0400000);
        run_op(32'h3F800000, 32'h40400000, "R4", 1'b0);   // 1 / 3
        chk(quotient == 32'h3EAAAAAB, "R4", "1/3 literal", quotient, 32'h3EAAAAAB);
        run_op(32'h40000000, 32'h3F800000, "R3", 1'b0);   // ratio >= 1
        run_op(32'h3F800000, 32'h3FC00000, "R3", 1'b0);   // ratio < 1
        run_op(32'h3F7FFFFF, 32'h3F800001, "R4", 1'b0);
        run_op(32'h7F000000, 32'h00800000, "R5", 1'b0);   // far overflow
        run_op(32'h7F000000, 32'h3F000000, "R5", 1'b0);   // exponent lands on 255
        run_op(32'h7F000000, 32'h3F400000, "R5", 1'b0);   // 254 stays finite
        run_op(32'h00800000, 32'h7F000000, "R6", 1'b0);   // far underflow
        run_op(32'h00800000, 32'h3FC00000, "R6", 1'b0);   // exponent lands on 0
        run_op(32'h00C00000, 32'h3F800000, "R6", 1'b0);   // exponent 1 stays normal
        run_op(32'h00000005, 32'h40000000, "R7", 1'b0);   // zero with fraction bits
        run_op(32'h00000000, 32'hBF800000, "R7", 1'b0);   // signed zero
        run_op(32'hBF800000, 32'h00000000, "R8", 1'b0);   // -1 / 0
        chk(quotient == 32'hFF800000 && flag_dz, "R8", "-inf literal", quotient, 32'hFF800000);
        run_op(32'h00000000, 32'h80000000, "R9", 1'b0);   // 0 / 0
        chk(quotient == 32'h7FC00000, "R9", "NaN literal", quotient, 32'h7FC00000);
        run_op(32'h40490FDB, 32'h402DF854, "R11", 1'b1);  // start poked while busy

        for (int n = 0; n < 40; n++) begin
            logic [31:0] a, b;
            lcg = lcg * 1664525 + 1013904223;
            a = {lcg[31], 8'(64 + (lcg[30:24] % 128)), lcg[22:0]};
            lcg = lcg * 1664525 + 1013904223;
            b = {lcg[31], 8'(64 + (lcg[30:24] % 128)), lcg[22:0]};
            run_op(a, b, "R4", 1'b0);
        end

        summary();
        $finish;
    end
endmodule